// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is a single DMA channel that copies data between two memory-mapped locations one beat at a time. Software loads a byte count, a source address, a destination address, a link word and a config word through a small register port. It then starts the channel by writing the config word with its enable bit set. Each beat reads one word at the source address and writes it to the destination address. After each beat both addresses may step forward and the count drops by the beat size.

When the count reaches zero, the channel looks at the link word. If the link word has its chain flag set, the channel reads the next 32-byte descriptor from memory into its working registers and carries on with no help from software. Otherwise it raises a one-cycle completion pulse and goes idle. While the channel runs, software can pause it by clearing the enable bit and resume it by setting the bit again. A memory response flagged as an error stops the channel and raises an error pulse. The remaining byte count is always visible on an output port.

Top module: `llc_dma_channel`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_req` are low, `remaining` is 0, and every register reads back 0.
- R2: Register word indices on `reg_addr`: 0 = link, 1 = count, 2 = source, 3 = destination, 4 = config, 5 = address of the descriptor in progress (read only, 0 until a descriptor is fetched). `reg_rdata` is valid the cycle after `reg_rd`.
- R3: Writing config with bit 0 set while idle raises `busy` the next cycle. Each beat issues a read of the source address and then a write of the read data to the destination address. Only one request is outstanding at a time, and `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.
- R4: The beat size is 2^min(config[14:12], 2) bytes. After each beat the count drops by the beat size, saturating at 0. The source steps by the beat size when config bit 31 is set, and the destination steps when config bit 30 is set.
- R5: `remaining` shows the live working count, zero-extended.
- R6: When the count reaches zero and link bit 1 is set, the channel fetches the descriptor at the link address with its low 5 bits cleared. The word at +0 becomes the link, and the words at +16, +20, +24 and +28 become count, source, destination and config. The config enable bit keeps its current value. The descriptor address register then reads that base address.
- R7: When the count reaches zero and link bit 1 is clear (a zero link included), `done` pulses for exactly one cycle, `busy` falls in the same cycle and config bit 0 reads 0. Starting with a count of 0 completes with no memory traffic.
- R8: Clearing config bit 0 while busy lets the current beat finish and then issues no more requests. `remaining` holds and `busy` stays high. Setting bit 0 again resumes from the held state.
- R9: Writes to link, count, source or destination while busy are ignored.
- R10: A response with `mem_err` set stops the channel. `err` pulses, `busy` falls, `done` stays low and config bit 0 reads 0.
- R11: `done` and `err` are never high together, and no request is raised while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle response to the request |
| mem_err | input | 1 | Response carries an error (valid with `mem_ack`) |
| mem_rdata | input | 32 | Read data (valid with `mem_ack`) |
| busy | output | 1 | Channel active (running or paused) |
| remaining | output | 16 | Live remaining byte count |
| done | output | 1 | One-cycle pulse when the final descriptor ends |
| err | output | 1 | One-cycle pulse on an error response |

## Verification
A wrong working count or a bad step would leave destination words holding the wrong source data. It would also change the number of memory writes, and both show up as soon as the run ends. A chain decode error would show as a missing copy region, an early completion pulse, or a wrong descriptor address on readback right after the final descriptor. A broken pause shows within a few cycles as memory requests or a moving `remaining` value while the enable bit is clear. A lost error stop shows in the same cycle as a completion pulse or a request raised with `busy` low.

// File: rtl/llc_pkg.sv
package llc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEAT,
    ST_RD,
    ST_WR,
    ST_NEXT,
    ST_FETCH,
    ST_HOLD
  } llc_state_e;

  localparam int CFG_EN       = 0;
  localparam int CFG_SRC_STEP = 31;
  localparam int CFG_DST_STEP = 30;
  localparam int CFG_SW_LSB   = 12;
  localparam int LINK_CHAIN   = 1;
  localparam int DESC_LOG     = 5;

  localparam logic [2:0] RG_LINK = 3'd0;
  localparam logic [2:0] RG_CNT  = 3'd1;
  localparam logic [2:0] RG_SRC  = 3'd2;
  localparam logic [2:0] RG_DST  = 3'd3;
  localparam logic [2:0] RG_CFG  = 3'd4;
  localparam logic [2:0] RG_DESC = 3'd5;

  localparam logic [2:0] FW_LINK = 3'd0;
  localparam logic [2:0] FW_CNT  = 3'd4;
  localparam logic [2:0] FW_SRC  = 3'd5;
  localparam logic [2:0] FW_DST  = 3'd6;
  localparam logic [2:0] FW_CFG  = 3'd7;
endpackage

// File: rtl/llc_stepper.sv
module llc_stepper #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic [2:0]        width_code,
  input  logic              src_step,
  input  logic              dst_step,
  input  logic [ADDR_W-1:0] src_cur,
  input  logic [ADDR_W-1:0] dst_cur,
  input  logic [CNT_W-1:0]  cnt_cur,
  output logic [ADDR_W-1:0] src_nxt,
  output logic [ADDR_W-1:0] dst_nxt,
  output logic [CNT_W-1:0]  cnt_nxt
);
  localparam int MAX_LOG = $clog2(DATA_W / 8);

  logic [2:0]       lg;
  logic [CNT_W-1:0] beat;

  always_comb begin
    lg      = (width_code > 3'(MAX_LOG)) ? 3'(MAX_LOG) : width_code;
    beat    = CNT_W'(1) << lg;
    cnt_nxt = (cnt_cur > beat) ? cnt_cur - beat : '0;
    src_nxt = src_step ? src_cur + ADDR_W'(beat) : src_cur;
    dst_nxt = dst_step ? dst_cur + ADDR_W'(beat) : dst_cur;
  end
endmodule

// File: rtl/llc_memif.sv
module llc_memif #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              issue_we,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (issue) begin
      mem_req   <= 1'b1;
      mem_we    <= issue_we;
      mem_addr  <= issue_addr;
      mem_wdata <= issue_wdata;
    end else if (mem_ack) begin
      mem_req <= 1'b0;
    end
  end

  assign rsp_valid = mem_req & mem_ack;
  assign rsp_err   = mem_err;
  assign rsp_data  = mem_rdata;
endmodule

// File: rtl/llc_dma_channel.sv
module llc_dma_channel #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13,
  parameter int REM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic [REM_W-1:0]  remaining,
  output logic              done,
  output logic              err
);
  import llc_pkg::*;

  llc_state_e        state_q;
  logic [31:0]       link_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] src_q, dst_q, fbase_q, desc_q;
  logic [31:0]       cfg_q;
  logic [2:0]        fidx_q, fidx_nx;
  logic              busy_q, done_q, err_q;

  logic              issue, issue_we;
  logic [ADDR_W-1:0] issue_addr;
  logic              rsp_valid, rsp_err;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] src_nx, dst_nx;
  logic [CNT_W-1:0]  cnt_nx;

  llc_stepper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_step (
    .width_code (cfg_q[CFG_SW_LSB+2:CFG_SW_LSB]),
    .src_step   (cfg_q[CFG_SRC_STEP]),
    .dst_step   (cfg_q[CFG_DST_STEP]),
    .src_cur    (src_q),
    .dst_cur    (dst_q),
    .cnt_cur    (cnt_q),
    .src_nxt    (src_nx),
    .dst_nxt    (dst_nx),
    .cnt_nxt    (cnt_nx)
  );

  llc_memif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk         (clk),
    .rst         (rst),
    .issue       (issue),
    .issue_we    (issue_we),
    .issue_addr  (issue_addr),
    .issue_wdata (rsp_data),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .mem_rdata   (mem_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_data    (rsp_data)
  );

  assign fidx_nx = (fidx_q == FW_LINK) ? FW_CNT : fidx_q + 3'd1;

  // Request generation: one outstanding access, chosen by the current state
  always_comb begin
    issue      = 1'b0;
    issue_we   = 1'b0;
    issue_addr = src_q;
    case (state_q)
      ST_BEAT: begin
        if (cfg_q[CFG_EN] && cnt_q != '0) issue = 1'b1;
      end
      ST_RD: begin
        if (rsp_valid && !rsp_err) begin
          issue      = 1'b1;
          issue_we   = 1'b1;
          issue_addr = dst_q;
        end
      end
      ST_NEXT: begin
        if (link_q[LINK_CHAIN]) begin
          issue      = 1'b1;
          issue_addr = {link_q[ADDR_W-1:DESC_LOG], {DESC_LOG{1'b0}}};
        end
      end
      ST_FETCH: begin
        if (rsp_valid && !rsp_err && fidx_q != FW_CFG) begin
          issue      = 1'b1;
          issue_addr = {fbase_q[ADDR_W-1:DESC_LOG], fidx_nx, 2'b00};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      link_q  <= '0;
      cnt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cfg_q   <= '0;
      fbase_q <= '0;
      desc_q  <= '0;
      fidx_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_BEAT: begin
          if (!cfg_q[CFG_EN])      state_q <= ST_HOLD;
          else if (cnt_q == '0)    state_q <= ST_NEXT;
          else                     state_q <= ST_RD;
        end
        ST_RD: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              err_q <= 1'b1; busy_q <= 1'b0; cfg_q[CFG_EN] <= 1'b0; state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              err_q <= 1'b1; busy_q <= 1'b0; cfg_q[CFG_EN] <= 1'b0; state_q <= ST_IDLE;
            end else begin
              src_q   <= src_nx;
              dst_q   <= dst_nx;
              cnt_q   <= cnt_nx;
              state_q <= ST_BEAT;
            end
          end
        end
        ST_NEXT: begin
          if (link_q[LINK_CHAIN]) begin
            fbase_q <= {link_q[ADDR_W-1:DESC_LOG], {DESC_LOG{1'b0}}};
            fidx_q  <= FW_LINK;
            state_q <= ST_FETCH;
          end else begin
            done_q        <= 1'b1;
            busy_q        <= 1'b0;
            cfg_q[CFG_EN] <= 1'b0;
            state_q       <= ST_IDLE;
          end
        end
        ST_FETCH: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              err_q <= 1'b1; busy_q <= 1'b0; cfg_q[CFG_EN] <= 1'b0; state_q <= ST_IDLE;
            end else begin
              fidx_q <= fidx_nx;
              case (fidx_q)
                FW_LINK: link_q <= rsp_data;
                FW_CNT:  cnt_q  <= rsp_data[CNT_W-1:0];
                FW_SRC:  src_q  <= rsp_data;
                FW_DST:  dst_q  <= rsp_data;
                default: begin
                  cfg_q   <= {rsp_data[31:1], cfg_q[CFG_EN]};
                  desc_q  <= fbase_q;
                  state_q <= ST_BEAT;
                end
              endcase
            end
          end
        end
        ST_HOLD: begin
          if (cfg_q[CFG_EN]) state_q <= ST_BEAT;
        end
        default: ;
      endcase

      // Software writes: working registers only while idle; config always
      if (reg_wr) begin
        case (reg_addr)
          RG_LINK: if (!busy_q) link_q <= reg_wdata;
          RG_CNT:  if (!busy_q) cnt_q  <= reg_wdata[CNT_W-1:0];
          RG_SRC:  if (!busy_q) src_q  <= reg_wdata;
          RG_DST:  if (!busy_q) dst_q  <= reg_wdata;
          RG_CFG: begin
            cfg_q <= reg_wdata;
            if (!busy_q && reg_wdata[CFG_EN]) begin
              busy_q  <= 1'b1;
              state_q <= ST_BEAT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RG_LINK: reg_rdata <= link_q;
        RG_CNT:  reg_rdata <= 32'(cnt_q);
        RG_SRC:  reg_rdata <= src_q;
        RG_DST:  reg_rdata <= dst_q;
        RG_CFG:  reg_rdata <= cfg_q;
        RG_DESC: reg_rdata <= desc_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign remaining = REM_W'(cnt_q);
endmodule

// File: rtl/llc_dma_channel_chk.sv
module llc_dma_channel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              busy,
  input logic              done,
  input logic              err
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_done_ends_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_stops_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && $past(busy)));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

bind llc_dma_channel llc_dma_channel_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .busy     (busy),
  .done     (done),
  .err      (err)
);

// File: tb/test_llc_dma_channel.sv
`timescale 1ns/1ps
module test_llc_dma_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, err;
  logic [15:0] remaining;

  int tests = 0, fails = 0;
  int done_cnt = 0, err_cnt = 0, wr_cnt = 0;
  logic [31:0] mem [0:511];

  localparam logic [31:0] CFG_STD = 32'hC000_2001;

  always #4 clk = ~clk;

  llc_dma_channel i_llc_dma_channel (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .busy(busy), .remaining(remaining), .done(done), .err(err)
  );

  // Memory model: one-cycle response, addresses at or above 0x800 answer with an error
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_err <= mem_addr[11];
        if (!mem_we) mem_rdata <= mem[mem_addr[10:2]];
        else if (!mem_addr[11]) begin
          mem[mem_addr[10:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (err)  err_cnt  <= err_cnt + 1;
  end

  function automatic logic [31:0] pat(int w);
    return 32'hC0DE0000 ^ (32'(w) * 32'h0001_0101);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic seed();
    for (int i = 0; i < 512; i++) mem[i] = pat(i);
  endtask

  task automatic put_desc(input int a, input logic [31:0] lk, cn, s, d, c);
    mem[a>>2] = lk; mem[(a>>2)+4] = cn; mem[(a>>2)+5] = s;
    mem[(a>>2)+6] = d; mem[(a>>2)+7] = c;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic prog(input logic [31:0] lk, cn, s, d, c);
    wr_reg(3'd0, lk); wr_reg(3'd1, cn); wr_reg(3'd2, s); wr_reg(3'd3, d); wr_reg(3'd4, c);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic chk_copy(input string req, input int s, input int d, input int words);
    for (int i = 0; i < words; i++)
      chk(mem[(d>>2)+i] == pat((s>>2)+i), req, mem[(d>>2)+i], pat((s>>2)+i));
  endtask

  initial begin
    #(8*150000);
    fails++; tests++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, r1, r2;
    int d0, e0, w0;
    seed();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !mem_req, "R1 outputs", {busy, done, err, mem_req}, 0);
    chk(remaining == 0, "R1 remaining", 32'(remaining), 0);
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), v);
      chk(v == 0, "R1 register", v, 0);
    end

    // R2 readback without starting (enable clear)
    prog(32'h1234_5662, 32'h0000_0ABC, 32'h0000_0440, 32'h0000_0550, 32'h4000_2000);
    rd_reg(3'd0, v); chk(v == 32'h1234_5662, "R2 link", v, 32'h1234_5662);
    rd_reg(3'd1, v); chk(v == 32'h0000_0ABC, "R2 count", v, 32'h0000_0ABC);
    rd_reg(3'd2, v); chk(v == 32'h0000_0440, "R2 source", v, 32'h0000_0440);
    rd_reg(3'd3, v); chk(v == 32'h0000_0550, "R2 destination", v, 32'h0000_0550);
    rd_reg(3'd4, v); chk(v == 32'h4000_2000, "R2 config", v, 32'h4000_2000);
    chk(!busy, "R2 no start without enable", 32'(busy), 0);
    chk(remaining == 16'h0ABC, "R5 remaining mirrors count", 32'(remaining), 32'h0ABC);

    // R3 R4 single descriptor, word beats
    seed(); d0 = done_cnt; w0 = wr_cnt;
    prog(0, 32, 32'h100, 32'h300, CFG_STD);
    chk(busy, "R3 busy after start", 32'(busy), 1);
    wait_idle(); @(negedge clk);
    chk_copy("R3 copy", 32'h100, 32'h300, 8);
    chk(wr_cnt - w0 == 8, "R4 write count", 32'(wr_cnt - w0), 8);
    chk(done_cnt - d0 == 1, "R7 done once", 32'(done_cnt - d0), 1);
    chk(remaining == 0, "R5 remaining end", 32'(remaining), 0);
    rd_reg(3'd4, v); chk(v[0] == 1'b0, "R7 enable cleared", v, CFG_STD & ~32'h1);
    rd_reg(3'd2, v); chk(v == 32'h120, "R4 source stepped", v, 32'h120);

    // R4 byte beats: 5 beats, destination byte 0x384 receives the word of 0x184
    seed(); w0 = wr_cnt;
    prog(0, 5, 32'h180, 32'h380, 32'hC000_0001);
    wait_idle(); @(negedge clk);
    chk(wr_cnt - w0 == 5, "R4 byte beats", 32'(wr_cnt - w0), 5);
    chk(mem[32'h384>>2] == pat(32'h184>>2), "R4 byte step", mem[32'h384>>2], pat(32'h184>>2));
    rd_reg(3'd3, v); chk(v == 32'h385, "R4 destination stepped", v, 32'h385);

    // R4 fixed source, width code above limit clamps to word
    seed(); w0 = wr_cnt;
    prog(0, 12, 32'h140, 32'h3C0, 32'h4000_3001);
    wait_idle(); @(negedge clk);
    chk(wr_cnt - w0 == 3, "R4 clamp beats", 32'(wr_cnt - w0), 3);
    for (int i = 0; i < 3; i++)
      chk(mem[(32'h3C0>>2)+i] == pat(32'h140>>2), "R4 fixed source", mem[(32'h3C0>>2)+i], pat(32'h140>>2));

    // R6 chain of three descriptors
    seed(); d0 = done_cnt; w0 = wr_cnt;
    put_desc(32'h600, 32'h622, 4, 32'h120, 32'h210, CFG_STD & ~32'h1);
    put_desc(32'h620, 0, 8, 32'h130, 32'h220, CFG_STD);
    prog(32'h602, 8, 32'h100, 32'h200, CFG_STD);
    wait_idle(); @(negedge clk);
    chk_copy("R6 first", 32'h100, 32'h200, 2);
    chk_copy("R6 second", 32'h120, 32'h210, 1);
    chk_copy("R6 third", 32'h130, 32'h220, 2);
    chk(wr_cnt - w0 == 5, "R6 write count", 32'(wr_cnt - w0), 5);
    chk(done_cnt - d0 == 1, "R6 done once at end", 32'(done_cnt - d0), 1);
    rd_reg(3'd5, v); chk(v == 32'h620, "R6 descriptor address", v, 32'h620);
    rd_reg(3'd0, v); chk(v == 0, "R6 link loaded", v, 0);

    // R7 nonzero link without chain flag stops
    seed(); d0 = done_cnt; w0 = wr_cnt;
    put_desc(32'h600, 0, 4, 32'h100, 32'h240, CFG_STD);
    prog(32'h600, 4, 32'h100, 32'h200, CFG_STD);
    wait_idle(); @(negedge clk);
    chk(wr_cnt - w0 == 1, "R7 no chain writes", 32'(wr_cnt - w0), 1);
    chk(mem[32'h240>>2] == pat(32'h240>>2), "R7 next untouched", mem[32'h240>>2], pat(32'h240>>2));
    chk(done_cnt - d0 == 1, "R7 done", 32'(done_cnt - d0), 1);

    // R7 zero count
    d0 = done_cnt; w0 = wr_cnt;
    prog(0, 0, 32'h100, 32'h200, CFG_STD);
    repeat (4) @(negedge clk);
    chk(!busy && done_cnt - d0 == 1, "R7 zero count done", 32'(done_cnt - d0), 1);
    chk(wr_cnt == w0, "R7 zero count no traffic", 32'(wr_cnt - w0), 0);

    // R8 pause and resume, R9 ignored writes while busy
    seed(); d0 = done_cnt; w0 = wr_cnt;
    prog(0, 64, 32'h100, 32'h300, CFG_STD);
    repeat (10) @(negedge clk);
    wr_reg(3'd1, 4); wr_reg(3'd2, 32'h180);
    chk(remaining != 4, "R9 count write ignored", 32'(remaining), 32'd64);
    wr_reg(3'd4, CFG_STD & ~32'h1);
    repeat (12) @(negedge clk);
    r1 = 32'(remaining); w0 = wr_cnt;
    repeat (20) @(negedge clk);
    r2 = 32'(remaining);
    chk(r1 == r2 && r1 != 0, "R8 remaining held", r2, r1);
    chk(busy && !mem_req, "R8 paused quiet", {busy, mem_req}, 2);
    chk(wr_cnt == w0, "R8 no writes while paused", 32'(wr_cnt - w0), 0);
    wr_reg(3'd4, CFG_STD);
    wait_idle(); @(negedge clk);
    chk_copy("R8 R9 full copy after resume", 32'h100, 32'h300, 16);
    chk(done_cnt - d0 == 1, "R8 done after resume", 32'(done_cnt - d0), 1);

    // R10 error on data read
    d0 = done_cnt; e0 = err_cnt; w0 = wr_cnt;
    prog(0, 16, 32'h900, 32'h300, CFG_STD);
    wait_idle(); @(negedge clk);
    chk(err_cnt - e0 == 1 && done_cnt == d0, "R10 data error", 32'(err_cnt - e0), 1);
    chk(wr_cnt == w0 && !busy, "R10 stopped", 32'(wr_cnt - w0), 0);
    rd_reg(3'd4, v); chk(v[0] == 1'b0, "R10 enable cleared", v, CFG_STD & ~32'h1);

    // R10 error on descriptor fetch
    e0 = err_cnt; d0 = done_cnt;
    prog(32'h802, 0, 32'h100, 32'h300, CFG_STD);
    wait_idle(); @(negedge clk);
    chk(err_cnt - e0 == 1 && done_cnt == d0, "R10 fetch error", 32'(err_cnt - e0), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule